// File: doc/BRIEF.md
# Paged Address Translation Unit

This block sits between a CPU with a 16-bit address bus and a 26-bit physical memory system. The upper four bits of every CPU address pick one of sixteen 4 KB frames. Each frame holds a 14-bit physical page number in a small register file. The page number is joined with the 12-bit in-page offset to form the physical address. Translation is purely combinational, so every CPU access sees the table as it stands at that moment.

Software changes the mapping through three 8-bit I/O ports in one port block:
- a frame-select register, which picks the table entry to access;
- a high-byte port, which stages the upper page bits;
- a low-byte port, which commits the staged upper bits together with the low byte into the selected entry.

After reset the table boots with a fixed map. ROM sits in the lowest frame, SRAM in the highest frame, and every frame in between maps to the SDRAM page with the same number. The translated address is also decoded into five one-hot region strobes. A 23-bit SDRAM byte address is produced in which the two 8 MB SDRAM halves alias each other.

Top module: `pxl_top`

## Requirements
- R1: The physical address is {page number of frame laddr[15:12], laddr[11:0]}. The offset bits pass through unchanged.
- R2: After reset, frame 0 holds page 0x2000 and frame 15 holds page 0x2001. Every frame n from 1 to 14 holds page n. The staging register for the high byte resets to 0.
- R3: A write to port 0xF8 loads wdata[3:0] into the frame-select register and ignores wdata[7:4]. Reading 0xF8 returns {4'b0, select}.
- R4: A write to port 0xFC stores wdata[5:0] in the staging register and ignores wdata[7:6]. It leaves the translation table unchanged.
- R5: A write to port 0xFD sets the selected entry to {staging[5:0], wdata}. The new page is visible on the physical address from the cycle after the write edge.
- R6: Reading 0xFC returns {2'b0, entry[13:8]} of the selected frame. Reading 0xFD returns entry[7:0]. Both read the committed entry, not the staging register.
- R7: The region output is one-hot with this bit order: bit0 cached SDRAM (phys < 0x1000000), bit1 uncached SDRAM (0x1000000–0x1FFFFFF), bit2 ROM (0x2000000–0x2000FFF), bit3 SRAM (0x2001000–0x2001FFF), bit4 unmapped (all else).
- R8: The SDRAM byte address is phys[22:0]. Bit 23 is dropped, so the upper 8 MB of each SDRAM window aliases the lower.
- R9: Only the three ports listed above are decoded. An access to any other port, or a write with io_wr low, changes no state, drives io_hit low and returns rdata 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| laddr | input | 16 | CPU logical address |
| paddr | output | 26 | Translated physical address |
| region | output | 5 | One-hot region decode of paddr |
| sdram_addr | output | 23 | SDRAM byte address (aliased) |
| io_addr | input | 8 | I/O port number |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data for a decoded port |
| io_hit | output | 1 | io_addr matches one of this block's ports |

## Verification
The in-RTL properties hold on every cycle and cover four things:
- the reset boot map;
- the low-byte commit of {staging, data} into the selected entry;
- the stability of the table across every cycle with no low-byte write, including high-byte writes;
- the one-hot property of the region strobes and the pass-through of the offset.

Only the bench scenarios can show the rest:
- the readback values of each port after a programming sequence;
- how page numbers land in the uncached, aliased and unmapped regions;
- that undecoded ports and unstrobed writes leave the selected frame and the mapping intact;
- that a second reset restores a modified map.

// File: rtl/pxl_pkg.sv
package pxl_pkg;

    parameter int LADDR_W = 16;
    parameter int OFF_W   = 12;
    parameter int PADDR_W = 26;
    parameter int BYTE_W  = 8;

    localparam int FRAME_W = LADDR_W - OFF_W;
    localparam int FRAMES  = 1 << FRAME_W;
    localparam int PAGE_W  = PADDR_W - OFF_W;
    localparam int HI_W    = PAGE_W - BYTE_W;

    localparam logic [PAGE_W-1:0] ROM_PAGE  = PAGE_W'(14'h2000);
    localparam logic [PAGE_W-1:0] SRAM_PAGE = PAGE_W'(14'h2001);

    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [PAGE_W-1:0]  page_t;
    typedef logic [HI_W-1:0]    hi_t;

    typedef enum logic [4:0] {
        RG_CACHED   = 5'b00001,
        RG_UNCACHED = 5'b00010,
        RG_ROM      = 5'b00100,
        RG_SRAM     = 5'b01000,
        RG_NONE     = 5'b10000
    } region_e;

    typedef enum logic [1:0] {
        PK_NONE = 2'd0,
        PK_SEL  = 2'd1,
        PK_HI   = 2'd2,
        PK_LO   = 2'd3
    } port_kind_e;

    typedef struct packed {
        logic  wr_sel;
        logic  wr_lo;
        frame_t sel;
        hi_t    hi;
        logic [BYTE_W-1:0] lo;
    } tbl_cmd_t;

    function automatic page_t boot_page(int idx);
        if (idx == 0)
            return ROM_PAGE;
        else if (idx == FRAMES - 1)
            return SRAM_PAGE;
        else
            return page_t'(idx);
    endfunction

    function automatic region_e page_region(page_t pg);
        if (!pg[PAGE_W-1])
            return pg[PAGE_W-2] ? RG_UNCACHED : RG_CACHED;
        else if (pg[PAGE_W-2:1] == '0)
            return pg[0] ? RG_SRAM : RG_ROM;
        else
            return RG_NONE;
    endfunction

endpackage

// File: rtl/pxl_port_if.sv
module pxl_port_if
    import pxl_pkg::*;
#(
    parameter logic [7:0] IO_BASE = 8'hF8,
    parameter int         SEL_OFS = 0,
    parameter int         HI_OFS  = 4,
    parameter int         LO_OFS  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        io_addr,
    input  logic              io_wr,
    input  logic [BYTE_W-1:0] io_wdata,
    input  page_t             sel_page,
    output tbl_cmd_t          cmd,
    output logic [BYTE_W-1:0] io_rdata,
    output logic              io_hit
);

    localparam logic [7:0] SEL_PORT = IO_BASE + 8'(SEL_OFS);
    localparam logic [7:0] HI_PORT  = IO_BASE + 8'(HI_OFS);
    localparam logic [7:0] LO_PORT  = IO_BASE + 8'(LO_OFS);

    port_kind_e kind;
    frame_t     sel_q;
    hi_t        hi_q;

    always_comb begin
        unique case (io_addr)
            SEL_PORT: kind = PK_SEL;
            HI_PORT:  kind = PK_HI;
            LO_PORT:  kind = PK_LO;
            default:  kind = PK_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            hi_q  <= '0;
        end else if (io_wr) begin
            if (kind == PK_SEL) sel_q <= io_wdata[FRAME_W-1:0];
            if (kind == PK_HI)  hi_q  <= io_wdata[HI_W-1:0];
        end
    end

    always_comb begin
        cmd.wr_sel = io_wr && (kind == PK_SEL);
        cmd.wr_lo  = io_wr && (kind == PK_LO);
        cmd.sel    = sel_q;
        cmd.hi     = hi_q;
        cmd.lo     = io_wdata;
    end

    always_comb begin
        io_hit   = (kind != PK_NONE);
        io_rdata = '0;
        case (kind)
            PK_SEL:  io_rdata = BYTE_W'(sel_q);
            PK_HI:   io_rdata = BYTE_W'(sel_page[PAGE_W-1:BYTE_W]);
            PK_LO:   io_rdata = sel_page[BYTE_W-1:0];
            default: io_rdata = '0;
        endcase
    end

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (io_wr && kind == PK_SEL) |=> sel_q == $past(io_wdata[FRAME_W-1:0])); // R3

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && kind == PK_SEL) |=> $stable(sel_q)); // R9

endmodule

// File: rtl/pxl_table.sv
module pxl_table
    import pxl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tbl_cmd_t cmd,
    input  frame_t   xl_frame,
    output page_t    xl_page,
    output page_t    sel_page
);

    logic [FRAMES-1:0][PAGE_W-1:0] ent_q;

    for (genvar gi = 0; gi < FRAMES; gi++) begin : g_ent
        page_t ent_r;
        always_ff @(posedge clk) begin
            if (rst)
                ent_r <= boot_page(gi);
            else if (cmd.wr_lo && cmd.sel == frame_t'(gi))
                ent_r <= {cmd.hi, cmd.lo};
        end
        assign ent_q[gi] = ent_r;
    end

    assign xl_page  = ent_q[xl_frame];
    assign sel_page = ent_q[cmd.sel];

    AST_BOOT_ROM: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ent_q[0] == ROM_PAGE); // R2

    AST_BOOT_SRAM: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ent_q[FRAMES-1] == SRAM_PAGE); // R2

    AST_LO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        cmd.wr_lo |=> ent_q[cmd.sel] == $past({cmd.hi, cmd.lo})); // R5

    AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cmd.wr_lo |=> $stable(ent_q)); // R4

endmodule

// File: rtl/pxl_region.sv
module pxl_region
    import pxl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  page_t              page,
    input  logic [OFF_W-1:0]   offset,
    output logic [PADDR_W-1:0] paddr,
    output region_e            region,
    output logic [22:0]        sdram_addr
);

    assign paddr      = {page, offset};
    assign region     = page_region(page);
    assign sdram_addr = paddr[22:0];

    AST_REGION_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot(region)); // R7

    AST_ROMSRAM_SPACE: assert property (@(posedge clk) disable iff (rst)
        (region == RG_ROM || region == RG_SRAM) |-> paddr[PADDR_W-1:OFF_W+1] == ROM_PAGE[PAGE_W-1:1]); // R7

endmodule

// File: rtl/pxl_top.sv
module pxl_top
    import pxl_pkg::*;
#(
    parameter logic [7:0] IO_BASE = 8'hF8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LADDR_W-1:0] laddr,
    output logic [PADDR_W-1:0] paddr,
    output logic [4:0]         region,
    output logic [22:0]        sdram_addr,
    input  logic [7:0]         io_addr,
    input  logic               io_wr,
    input  logic [BYTE_W-1:0]  io_wdata,
    output logic [BYTE_W-1:0]  io_rdata,
    output logic               io_hit
);

    tbl_cmd_t cmd;
    page_t    sel_page;
    page_t    xl_page;
    region_e  region_w;

    pxl_port_if #(.IO_BASE(IO_BASE)) u_port (
        .clk      (clk),
        .rst      (rst),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .sel_page (sel_page),
        .cmd      (cmd),
        .io_rdata (io_rdata),
        .io_hit   (io_hit)
    );

    pxl_table u_table (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .xl_frame (laddr[LADDR_W-1:OFF_W]),
        .xl_page  (xl_page),
        .sel_page (sel_page)
    );

    pxl_region u_region (
        .clk        (clk),
        .rst        (rst),
        .page       (xl_page),
        .offset     (laddr[OFF_W-1:0]),
        .paddr      (paddr),
        .region     (region_w),
        .sdram_addr (sdram_addr)
    );

    assign region = region_w;

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        paddr[OFF_W-1:0] == laddr[OFF_W-1:0]); // R1

endmodule

// File: tb/tb_pxl_top.sv
module tb_pxl_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] laddr = '0;
    logic [25:0] paddr;
    logic [4:0]  region;
    logic [22:0] sdram_addr;
    logic [7:0]  io_addr = '0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_hit;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pxl_top dut (
        .clk(clk), .rst(rst), .laddr(laddr), .paddr(paddr), .region(region),
        .sdram_addr(sdram_addr), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_hit(io_hit)
    );

    localparam logic [4:0] C_CACH = 5'b00001;
    localparam logic [4:0] C_UNC  = 5'b00010;
    localparam logic [4:0] C_ROM  = 5'b00100;
    localparam logic [4:0] C_SRAM = 5'b01000;
    localparam logic [4:0] C_NONE = 5'b10000;

    // {laddr, expected paddr, expected region} against the boot map
    localparam int NV = 6;
    localparam logic [46:0] VEC [NV] = '{
        {16'h0123, 26'h2000123, C_ROM},
        {16'h1ABC, 26'h0001ABC, C_CACH},
        {16'h7456, 26'h0007456, C_CACH},
        {16'hE000, 26'h000E000, C_CACH},
        {16'hF000, 26'h2001000, C_SRAM},
        {16'hFFFF, 26'h2001FFF, C_SRAM}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr  = a;
        io_wdata = d;
        io_wr    = 1'b1;
        @(negedge clk);
        io_wr    = 1'b0;
        #1;
    endtask

    task automatic io_read(input logic [7:0] a);
        io_addr = a;
        #1;
    endtask

    task automatic xlate(input logic [15:0] a);
        laddr = a;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();

        // R2 reset state of the select register and boot map
        io_read(8'hF8);
        check("R2 select after reset", io_rdata, 8'h00);
        io_read(8'hFC);
        check("R2 frame0 hi after reset", io_rdata, 8'h20);

        // R1 R7 vector walk over the boot map
        for (int i = 0; i < NV; i++) begin
            xlate(VEC[i][46:31]);
            check("R1 paddr vector", paddr, VEC[i][30:5]);
            check("R7 region vector", region, VEC[i][4:0]);
        end

        // R3 select write with upper bits ignored
        io_write(8'hF8, 8'hF1);
        io_read(8'hF8);
        check("R3 select readback", io_rdata, 8'h01);
        check("R3 select hit", io_hit, 1'b1);

        // R4 staging write leaves translation unchanged
        io_write(8'hFC, 8'h01);
        xlate(16'h1234);
        check("R4 no commit on hi write", paddr, 26'h0001234);
        io_read(8'hFC);
        check("R6 hi reads committed entry", io_rdata, 8'h00);

        // R5 commit on low write
        io_write(8'hFD, 8'h00);
        xlate(16'h1234);
        check("R5 committed paddr", paddr, 26'h0100234);
        check("R5 cached region", region, C_CACH);
        io_read(8'hFC);
        check("R6 hi readback", io_rdata, 8'h01);
        io_read(8'hFD);
        check("R6 lo readback", io_rdata, 8'h00);

        // R4 R5 upper hi bits dropped, unmapped region
        io_write(8'hF8, 8'h03);
        io_write(8'hFC, 8'hFF);
        io_write(8'hFD, 8'h34);
        xlate(16'h3ABC);
        check("R5 masked page paddr", paddr, 26'h3F34ABC);
        check("R7 unmapped region", region, C_NONE);
        io_read(8'hFC);
        check("R6 hi masked readback", io_rdata, 8'h3F);

        // R7 R8 uncached window
        io_write(8'hF8, 8'h02);
        io_write(8'hFC, 8'h10);
        io_write(8'hFD, 8'h80);
        xlate(16'h2010);
        check("R7 uncached paddr", paddr, 26'h1080010);
        check("R7 uncached region", region, C_UNC);
        check("R8 uncached sdram addr", sdram_addr, 23'h080010);

        // R8 alias in the cached window
        io_write(8'hF8, 8'h04);
        io_write(8'hFC, 8'h08);
        io_write(8'hFD, 8'h05);
        xlate(16'h4FFF);
        check("R8 alias region", region, C_CACH);
        check("R8 alias sdram addr", sdram_addr, 23'h005FFF);

        // R9 undecoded ports and unstrobed writes
        io_write(8'hF9, 8'h0A);
        io_write(8'hFE, 8'h55);
        io_read(8'hF9);
        check("R9 undecoded rdata", io_rdata, 8'h00);
        check("R9 undecoded hit", io_hit, 1'b0);
        io_read(8'hF8);
        check("R9 select unchanged", io_rdata, 8'h04);
        @(negedge clk);
        io_addr = 8'hFD; io_wdata = 8'hAA; io_wr = 1'b0;
        @(negedge clk);
        xlate(16'h4FFF);
        check("R9 table unchanged", paddr, 26'h0805FFF);

        // R2 second reset restores boot map and clears staging
        do_reset();
        xlate(16'h1234);
        check("R2 frame1 restored", paddr, 26'h0001234);
        xlate(16'h3000);
        check("R2 frame3 restored", paddr, 26'h0003000);
        io_write(8'hF8, 8'h05);
        io_write(8'hFD, 8'h77);
        xlate(16'h5001);
        check("R2 staging zero after reset", paddr, 26'h0077001);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule